// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Source Dispatch

This block gathers single-cycle event pulses from up to 160 peripheral sources into five 32-bit banks. Every bank owns a latched status word and an enable word. A pulse sets its status bit even when the source is disabled. A status bit counts as pending only when its enable bit is also set. Banks 0 to 2 carry functional events and drive one combined output line. Banks 3 and 4 carry error events and drive a second line.

A dispatch port names the next source to service. It searches the banks from bank 0 upward and, inside a bank, takes the lowest pending bit. The source number is `32*bank + bit`. Once a source is presented it stays on the port until it is cleared or masked. A small synchronous register bus reads and writes the enable words, reads the status words and clears status bits by writing 1.

Top module: `irq_aggregator_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every enable and status bit reads 0, and `fn_irq_o`, `err_irq_o` and `disp_valid_o` are 0.
- R2: A 1 on `src_pulse_i[32*b+k]` sets status bit k of bank b at the next clock edge, whatever the value of the enable bit.
- R3: A bus write to a status word clears every bit that is 1 in the write data. Bits that are 0 in the write data keep their value.
- R4: When a source pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable words are ordinary read/write registers. Address `{bank[2:0], 1'b0}` selects the enable word and `{bank[2:0], 1'b1}` selects the status word. Read data appears on `bus_rdata_o` one cycle after `bus_rd_i`.
- R6: Bank 2 implements bits 0 to 23 and bank 4 implements bits 0 to 16. All other bits of those banks read as 0 and can be set neither by a pulse nor by a write.
- R7: `fn_irq_o` is 1 one cycle after any bank 0 to 2 bit has both its status and enable bits set, and 0 otherwise.
- R8: `err_irq_o` follows the same rule for banks 3 and 4.
- R9: When the port has no held source, `disp_src_o` gives the pending source in the lowest bank, taking the lowest bit in that bank. The number is `32*bank + bit`, and `disp_valid_o` is 1 whenever any source is pending.
- R10: A presented source stays on `disp_src_o` while it remains pending, even when a higher-priority source becomes pending. After that source is cleared or masked, the port reselects on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse_i | input | 160 | Single-cycle event pulses, bit 32*b+k feeds bank b bit k |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | {bank, word select}, word select 0 = enable, 1 = status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fn_irq_o | output | 1 | Any enabled pending source in banks 0 to 2 |
| err_irq_o | output | 1 | Any enabled pending source in banks 3 and 4 |
| disp_valid_o | output | 1 | Dispatch port holds a pending source |
| disp_src_o | output | 8 | Source number being dispatched |

## Verification
A source pulse and a write-1-to-clear can hit the same status bit in the same clock cycle. The bench drives both on one edge and then reads the status word back. It expects the bit to still be set. A second case covers a lower-numbered source that becomes pending while another is being dispatched. The bench checks that the held number does not change until that source is cleared, and that the port then moves to the lower source on the following cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = 32;
  localparam int FN_BANKS  = 3;
  localparam int SRC_W     = NUM_BANKS * BANK_W;
  localparam int SRC_IDX_W = 8;

  // number of implemented bits in each bank
  function automatic int bank_width(input int b);
    case (b)
      2:       return 24;
      4:       return 17;
      default: return 32;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_mask(input int b);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = (i < bank_width(b));
    return m;
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  input  logic         wr_ctl_i,
  input  logic         wr_sts_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctl_o,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] ctl_q, sts_q, clr_w;

  assign clr_w = wr_sts_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr_ctl_i) ctl_q <= wdata_i & MASK;
      // new events take precedence over a same-cycle clear
      sts_q <= ((sts_q & ~clr_w) | ev_i) & MASK;
    end
  end

  assign ctl_o  = ctl_q;
  assign sts_o  = sts_q;
  assign pend_o = sts_q & ctl_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (|(ev_i & MASK)) |=> ((sts_q & $past(ev_i & MASK)) == $past(ev_i & MASK)));
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    wr_sts_i |=> ((sts_q & $past(wdata_i & ~ev_i)) == '0));
  assert_ctl_rw_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ctl_i |=> (ctl_q == $past(wdata_i & MASK)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 160,
  parameter int IW = 8
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = IW'(i);
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_aggregator_top.sv
module irq_aggregator_top
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [SRC_W-1:0]    src_pulse_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [3:0]          bus_addr_i,
  input  logic [BANK_W-1:0]   bus_wdata_i,
  output logic [BANK_W-1:0]   bus_rdata_o,
  output logic                fn_irq_o,
  output logic                err_irq_o,
  output logic                disp_valid_o,
  output logic [SRC_IDX_W-1:0] disp_src_o
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] ctl_w, sts_w, pend_w;
  logic [SRC_W-1:0] pend_flat;
  logic [2:0] sel_bank;
  logic sel_sts;

  assign sel_bank = bus_addr_i[3:1];
  assign sel_sts  = bus_addr_i[0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(.W(BANK_W), .MASK(bank_mask(b))) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ev_i     (src_pulse_i[b*BANK_W +: BANK_W]),
      .wr_ctl_i (bus_wr_i && sel_bank == 3'(b) && !sel_sts),
      .wr_sts_i (bus_wr_i && sel_bank == 3'(b) &&  sel_sts),
      .wdata_i  (bus_wdata_i),
      .ctl_o    (ctl_w[b]),
      .sts_o    (sts_w[b]),
      .pend_o   (pend_w[b])
    );
  end

  assign pend_flat = pend_w;

  logic                 any_pend;
  logic [SRC_IDX_W-1:0] first_src;

  irq_pick #(.N(SRC_W), .IW(SRC_IDX_W)) u_pick (
    .vec_i (pend_flat),
    .any_o (any_pend),
    .idx_o (first_src)
  );

  logic cur_pend;
  assign cur_pend = disp_valid_o && pend_flat[disp_src_o];

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_irq_o     <= 1'b0;
      err_irq_o    <= 1'b0;
      disp_valid_o <= 1'b0;
      disp_src_o   <= '0;
      bus_rdata_o  <= '0;
    end else begin
      fn_irq_o  <= |pend_w[FN_BANKS-1:0];
      err_irq_o <= |pend_w[NUM_BANKS-1:FN_BANKS];
      if (!cur_pend) begin
        disp_valid_o <= any_pend;
        disp_src_o   <= first_src;
      end
      if (bus_rd_i) begin
        if (int'(sel_bank) < NUM_BANKS)
          bus_rdata_o <= sel_sts ? sts_w[sel_bank] : ctl_w[sel_bank];
        else
          bus_rdata_o <= '0;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!fn_irq_o && !err_irq_o && !disp_valid_o));
  assert_disp_line_R9: assert property (@(posedge clk) disable iff (rst)
    disp_valid_o |-> (fn_irq_o || err_irq_o));
  assert_disp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_valid_o && pend_flat[disp_src_o]) |=> (disp_valid_o && $stable(disp_src_o)));
endmodule

// File: tb/irq_aggregator_top_tb_top.sv
module irq_aggregator_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [159:0] src_pulse;
  logic         bus_wr, bus_rd;
  logic [3:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         fn_irq, err_irq, disp_valid;
  logic [7:0]   disp_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  irq_aggregator_top dut_i (
    .clk(clk), .rst(rst), .src_pulse_i(src_pulse),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .fn_irq_o(fn_irq), .err_irq_o(err_irq),
    .disp_valid_o(disp_valid), .disp_src_o(disp_src)
  );

  // scoreboard for register reads
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] bank, input logic sts, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = {bank, sts}; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] bank, input logic sts, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = {bank, sts};
    tick(1);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [159:0] p);
    src_pulse = p;
    tick(1);
    src_pulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; src_pulse = '0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tick(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 fn", fn_irq, 0);
    check("R1 err", err_irq, 0);
    check("R1 disp", disp_valid, 0);
    for (int b = 0; b < 5; b++) begin
      bus_read(3'(b), 0, 0, "R1 ctl");
      bus_read(3'(b), 1, 0, "R1 sts");
    end
    // R2 pulse sets status while disabled; R7 no output
    pulse(160'(1) << 5);
    bus_read(0, 1, 32'h20, "R2 status set while masked");
    check("R7 masked fn", fn_irq, 0);
    // R5 enable write/readback, R7 fn line, R9 dispatch
    bus_write(0, 0, 32'hFFFF_FFFF);
    bus_read(0, 0, 32'hFFFF_FFFF, "R5 ctl readback");
    tick(1);
    check("R7 fn high", fn_irq, 1);
    check("R9 disp valid", disp_valid, 1);
    check("R9 disp src5", disp_src, 5);
    // R10 hold against higher-priority source
    pulse(160'(1) << 3);
    tick(2);
    check("R10 hold src5", disp_src, 5);
    bus_write(0, 1, 32'h20);
    tick(1);
    check("R10 reselect src3", disp_src, 3);
    // R3 write of zero keeps bits
    bus_write(0, 1, 32'h0);
    bus_read(0, 1, 32'h08, "R3 zero write no effect");
    // R4 set wins over same-cycle clear
    src_pulse = 160'(1) << 3;
    bus_wr = 1; bus_addr = {3'd0, 1'b1}; bus_wdata = 32'h08;
    tick(1);
    src_pulse = '0; bus_wr = 0;
    bus_read(0, 1, 32'h08, "R4 set beats clear");
    // R8 error line, R9 bank order
    bus_write(3, 0, 32'h1);
    pulse(160'(1) << 96);
    tick(1);
    check("R8 err high", err_irq, 1);
    check("R9 bank0 first", disp_src, 3);
    bus_write(0, 1, 32'h08);
    tick(1);
    check("R9 src96", disp_src, 8'd96);
    check("R7 fn low", fn_irq, 0);
    // R10 masking releases dispatch
    bus_write(3, 0, 32'h0);
    tick(1);
    check("R10 masked release", disp_valid, 0);
    check("R8 err low", err_irq, 0);
    // R6 unimplemented bits
    bus_write(2, 0, 32'hFFFF_FFFF);
    bus_read(2, 0, 32'h00FF_FFFF, "R6 bank2 ctl");
    bus_write(4, 0, 32'hFFFF_FFFF);
    bus_read(4, 0, 32'h0001_FFFF, "R6 bank4 ctl");
    pulse({32'hFFFF_FFFF, 32'h0, 32'hFF00_0000, 64'h0});
    bus_read(4, 1, 32'h0001_FFFF, "R6 bank4 sts");
    bus_read(2, 1, 32'h0, "R6 bank2 sts");
    check("R8 err bank4", err_irq, 1);
    check("R9 src128", disp_src, 8'd128);
    tick(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule